// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out store that sits between two independent clock domains. A producer writes 18-bit words on its own clock while a write enable is high. A consumer takes words on a separate read clock while a read enable is high. The depth is a parameter and can be 512, 1024 or 2048 words. The default is 2048.

Three active-low status pins come out of the block:
- A shared empty-or-full pin.
- A half-full pin.
- A shared almost-empty-or-almost-full pin.

The almost thresholds are parameters and default to 16 words on each side. The empty-side state is worked out only on read-clock edges and the full-side state only on write-clock edges. Every read-clock edge refreshes the read-side status, whether or not the read enable is high.

The two pointers cross the clock boundary as Gray codes through two-stage synchronizers. Each side works out the occupancy from its own pointer and the synchronized copy of the other pointer. The almost-empty indication has a two-word hysteresis on the way up. Once set, it stays set until the occupancy reaches the threshold plus two, so the pin does not chatter around the threshold. Read data is registered and comes out one read-clock edge after the read is accepted.

Top module: `flagged_async_fifo`

## Requirements
- R1: While rst_ni is low, empty_full_n_o and almost_n_o are low, half_full_n_o is high and rdata_o is zero.
- R2: Accepted words come out on rdata_o in write order. Each word appears after the read-clock edge that accepts its read.
- R3: A write while the FIFO is full is dropped. No word is stored and the write pointer does not move.
- R4: A read while the FIFO is empty is ignored. rdata_o keeps its last value and the read pointer does not move.
- R5: empty_full_n_o is low when the read-side occupancy is 0 or the write-side occupancy equals DEPTH. It is high otherwise.
- R6: half_full_n_o is low exactly when the occupancy is greater than DEPTH/2.
- R7: almost_n_o is low when the almost-empty state is set or the occupancy is at least DEPTH-AF_OFS. The almost-empty state is set whenever the occupancy is at most AE_OFS.
- R8: The almost-empty state clears only when the occupancy is at least AE_OFS+2. At exactly AE_OFS+1 it keeps its previous value.
- R9: A read-clock edge with rd_en_i low re-evaluates the read-side flags but consumes no word.
- R10: A write is reflected in the read-side flags, and a read in the write-side flags, no later than the third edge of the opposite clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write request, sampled on wclk_i |
| wdata_i | input | DATA_W | Word to write |
| rd_en_i | input | 1 | Read request, sampled on rclk_i |
| rdata_o | output | DATA_W | Registered read word |
| empty_full_n_o | output | 1 | Low when empty (read side) or full (write side) |
| half_full_n_o | output | 1 | Low when more than half full |
| almost_n_o | output | 1 | Low when almost empty or almost full |

## Verification
The FIFO is first filled one word at a time, from empty to DEPTH, and then drained one word at a time back to empty. The bench lets the flags settle after every step and checks them against a queue model. Walking every count in both directions tells apart the set and clear points of each flag, and it shows the two-word almost-empty hysteresis, which differs between rising and falling occupancy. A write at full and reads at empty show whether the guards drop the request or corrupt the stream. A burst phase runs back-to-back writes and reads at the same time on the two clocks, which exposes errors in pointer crossing and address wrap that single steps would hide.

// File: rtl/fafifo_pkg.sv
package fafifo_pkg;
  localparam int unsigned DEF_DEPTH  = 2048;
  localparam int unsigned DEF_DATA_W = 18;
  localparam int unsigned DEF_OFS    = 16;

  typedef struct packed {
    logic full;
    logic afull;
    logic hfull;
  } wflags_t;

  typedef struct packed {
    logic empty;
    logic aempty;
  } rflags_t;
endpackage

// File: rtl/fafifo_sync.sv
// Two-stage synchronizer for a Gray pointer, binary result out.
module fafifo_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/fafifo_ram.sv
module fafifo_ram #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 11
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] rd_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/fafifo_wr_ctl.sv
module fafifo_wr_ctl
  import fafifo_pkg::*;
#(
  parameter  int unsigned DEPTH  = DEF_DEPTH,
  parameter  int unsigned AF_OFS = DEF_OFS,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rbin_i,
  output logic [PW-1:0] wgray_o,
  output logic [AW-1:0] waddr_o,
  output logic          we_o,
  output wflags_t       flags_o
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] AF_LVL  = PW'(DEPTH - AF_OFS);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  logic [PW-1:0] wbin_q, wbin_nx, wgray_q, occ_nx;
  logic          push;
  wflags_t       flags_q;

  assign push    = wr_en_i & ~flags_q.full;
  assign wbin_nx = wbin_q + PW'(push);
  assign occ_nx  = wbin_nx - rbin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      flags_q <= '0;
    end else begin
      wbin_q        <= wbin_nx;
      wgray_q       <= wbin_nx ^ (wbin_nx >> 1);
      flags_q.full  <= (occ_nx == DEPTH_P);
      flags_q.afull <= (occ_nx >= AF_LVL);
      flags_q.hfull <= (occ_nx > HALF_P);
    end
  end

  assign wgray_o = wgray_q;
  assign waddr_o = wbin_q[AW-1:0];
  assign we_o    = push;
  assign flags_o = flags_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && flags_q.full) |=> $stable(wbin_q));

  assert_occ_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_nx <= DEPTH_P);

  // one bit per step keeps the crossing safe (R10)
  assert_gray_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wgray_q ^ $past(wgray_q)));
endmodule

// File: rtl/fafifo_rd_ctl.sv
module fafifo_rd_ctl
  import fafifo_pkg::*;
#(
  parameter  int unsigned DEPTH  = DEF_DEPTH,
  parameter  int unsigned AE_OFS = DEF_OFS,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wbin_i,
  output logic [PW-1:0] rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          re_o,
  output rflags_t       flags_o
);
  localparam logic [PW-1:0] AE_LVL = PW'(AE_OFS);
  localparam logic [PW-1:0] AE_CLR = PW'(AE_OFS + 2);

  logic [PW-1:0] rbin_q, rbin_nx, rgray_q, occ_nx;
  logic          pop;
  rflags_t       flags_q;

  assign pop     = rd_en_i & ~flags_q.empty;
  assign rbin_nx = rbin_q + PW'(pop);
  assign occ_nx  = wbin_i - rbin_nx;

  // Every edge refreshes the flags, enabled or not.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q         <= '0;
      rgray_q        <= '0;
      flags_q.empty  <= 1'b1;
      flags_q.aempty <= 1'b1;
    end else begin
      rbin_q        <= rbin_nx;
      rgray_q       <= rbin_nx ^ (rbin_nx >> 1);
      flags_q.empty <= (occ_nx == '0);
      if (occ_nx <= AE_LVL)      flags_q.aempty <= 1'b1;
      else if (occ_nx >= AE_CLR) flags_q.aempty <= 1'b0;
    end
  end

  assign rgray_o = rgray_q;
  assign raddr_o = rbin_q[AW-1:0];
  assign re_o    = pop;
  assign flags_o = flags_q;

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && flags_q.empty) |=> $stable(rbin_q));

  assert_idle_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rbin_q));

  assert_ae_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_q.aempty) |-> $past(occ_nx) >= AE_CLR);

  assert_ae_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q.aempty) |-> $past(occ_nx) <= AE_LVL);

  assert_gray_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rgray_q ^ $past(rgray_q)));
endmodule

// File: rtl/flagged_async_fifo.sv
module flagged_async_fifo
  import fafifo_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned AE_OFS = DEF_OFS,
  parameter int unsigned AF_OFS = DEF_OFS
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_full_n_o,
  output logic              half_full_n_o,
  output logic              almost_n_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wbin_rs, rbin_ws;
  logic [AW-1:0] waddr, raddr;
  logic          we, re;
  wflags_t       wflags;
  rflags_t       rflags;

  fafifo_wr_ctl #(.DEPTH(DEPTH), .AF_OFS(AF_OFS)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rbin_i(rbin_ws),
    .wgray_o(wgray), .waddr_o(waddr), .we_o(we), .flags_o(wflags)
  );

  fafifo_rd_ctl #(.DEPTH(DEPTH), .AE_OFS(AE_OFS)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .wbin_i(wbin_rs),
    .rgray_o(rgray), .raddr_o(raddr), .re_o(re), .flags_o(rflags)
  );

  fafifo_sync #(.W(PW)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wbin_rs)
  );

  fafifo_sync #(.W(PW)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rbin_ws)
  );

  fafifo_ram #(.DW(DATA_W), .AW(AW)) u_ram (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .rclk_i(rclk_i), .rst_ni(rst_ni), .re_i(re), .raddr_i(raddr),
    .rdata_o(rdata_o)
  );

  assign empty_full_n_o = ~(rflags.empty | wflags.full);
  assign half_full_n_o  = ~wflags.hfull;
  assign almost_n_o     = ~(rflags.aempty | wflags.afull);

  assert_rdata_hold_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !re |=> $stable(rdata_o));
endmodule

// File: tb/flagged_async_fifo_bench.sv
module flagged_async_fifo_bench;
  localparam int DEPTH = 2048;
  localparam int DW    = 18;
  localparam int AE    = 16;
  localparam int AF    = 16;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0, rdata;
  logic          ef_n, hf_n, al_n;

  flagged_async_fifo #(.DEPTH(DEPTH), .DATA_W(DW), .AE_OFS(AE), .AF_OFS(AF)) u_flagged_async_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .empty_full_n_o(ef_n),
    .half_full_n_o(hf_n), .almost_n_o(al_n)
  );

  always #5 wclk = ~wclk;
  initial begin
    #3;
    forever #5 rclk = ~rclk;
  end

  int            checks = 0, errors = 0;
  logic [DW-1:0] model_q[$];
  bit            ae_m = 1'b1;
  logic [DW-1:0] last_rd = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // four write-clock periods cover three edges of either clock (R10)
  task automatic settle();
    repeat (4) @(negedge wclk);
  endtask

  task automatic check_flags();
    int cnt;
    cnt = model_q.size();
    if (cnt <= AE)          ae_m = 1'b1;
    else if (cnt >= AE + 2) ae_m = 1'b0;
    chk("R5/R10", "empty_full_n", 32'(ef_n), 32'(!(cnt == 0 || cnt == DEPTH)));
    chk("R6", "half_full_n", 32'(hf_n), 32'(!(cnt > DEPTH / 2)));
    chk((cnt == AE + 1) ? "R8" : "R7/R9", "almost_n", 32'(al_n),
        32'(!(ae_m || cnt >= DEPTH - AF)));
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en = 1'b1;
    wdata = d;
    @(negedge wclk);
    wr_en = 1'b0;
    if (model_q.size() < DEPTH) model_q.push_back(d);
  endtask

  task automatic do_read();
    logic [DW-1:0] exp;
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    if (model_q.size() > 0) begin
      exp = model_q.pop_front();
      chk("R2/R9", "rdata", 32'(rdata), 32'(exp));
      last_rd = exp;
    end else begin
      chk("R4", "rdata held", 32'(rdata), 32'(last_rd));
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 5) ^ (i << 7));
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge wclk);
    // R1: reset values
    chk("R1", "empty_full_n", 32'(ef_n), 32'd0);
    chk("R1", "almost_n", 32'(al_n), 32'd0);
    chk("R1", "half_full_n", 32'(hf_n), 32'd1);
    chk("R1", "rdata", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    settle();
    check_flags();

    // R4: read on empty
    do_read();
    settle();
    check_flags();

    // fill one word at a time: R5 R6 R7 R8 on the way up
    for (int i = 0; i < DEPTH; i++) begin
      do_write(pat(i));
      settle();
      check_flags();
    end

    // R3: write while full is dropped
    do_write(18'h2aaaa);
    settle();
    chk("R3", "still full", 32'(ef_n), 32'd0);
    check_flags();

    // drain: data order (R2) and hysteresis on the way down
    for (int i = 0; i < DEPTH; i++) begin
      do_read();
      settle();
      check_flags();
    end

    do_read();
    settle();
    check_flags();

    // burst with both clocks busy
    for (int i = 0; i < 64; i++) begin
      do_write(pat(i + 5000));
      settle();
    end
    check_flags();
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          @(negedge wclk);
          wr_en = 1'b1;
          wdata = pat(i + 9000);
          model_q.push_back(pat(i + 9000));
        end
        @(negedge wclk);
        wr_en = 1'b0;
      end
      begin
        @(negedge rclk);
        rd_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
          @(negedge rclk);
          chk("R2", "burst rdata", 32'(rdata), 32'(model_q.pop_front()));
        end
        rd_en = 1'b0;
      end
    join
    settle();
    check_flags();

    while (model_q.size() > 0) begin
      do_read();
      settle();
      check_flags();
    end

    finish_run();
  end
endmodule